// File: doc/BRIEF.md
# Audio Codec Controller Register File

This block is the software-visible register file of an audio codec controller. A processor reaches it over a simple 32-bit word bus with a byte address, a write strobe, write data and combinational read data. One group of registers drives codec register accesses: a control word, the codec register number, outgoing data and incoming data. Two further groups each hold a control word, a memory address and a byte count. One group serves the playback DMA channel and the other serves the capture DMA channel.

Writing the codec control word with its request bit set starts a codec transaction. The block answers with a one-cycle pulse on one of two event outputs, and the direction bit picks which one. The request bit is never stored. The channel enable bits and the programmed address and count values go straight out to the DMA engines. While a transfer runs, the DMA engines write back new address and count values through a dedicated update port. A bus write to the same register in the same cycle takes precedence over the update.

Top module: `audio_ctrl_regs`

## Requirements
- R1: Word offsets (byte address divided by 4) are 0 codec control, 1 codec register number, 2 codec out data, 3 codec in data, 4 playback control, 5 playback address, 6 playback count, 7 reserved, 8 capture control, 9 capture address, 10 capture count. A written value reads back in full, and the read data follows the address combinationally.
- R2: Address bits [1:0] are ignored, so every access acts on a whole 32-bit word.
- R3: A write to codec control with bit 0 = 1 and bit 1 = 1 raises `codec_req_pulse` for exactly one cycle, in the cycle after the write. `codec_reply_pulse` stays low.
- R4: A write to codec control with bit 0 = 1 and bit 1 = 0 raises `codec_reply_pulse` for exactly one cycle, in the cycle after the write. `codec_req_pulse` stays low.
- R5: Bit 0 of codec control always reads back as 0. All other bits read back as written. A write with bit 0 = 0 raises neither pulse.
- R6: `play_en` and `cap_en` equal bit 0 of the playback and capture control words.
- R7: Reset clears every register to zero and holds both pulses low.
- R8: Reads of offset 7 and of offsets 11 and above return zero. Writes to those offsets change no register.
- R9: An update strobe (`play_upd` / `cap_upd`) loads that channel's address and count from the update inputs on the next clock edge.
- R10: When a bus write hits a channel's address or count register in the same cycle as that channel's update strobe, the bus value is stored in that register. The other register of the pair still takes the update value.
- R11: The outputs `codec_reg_num`, `codec_out_data`, `play_addr`, `play_count`, `cap_addr` and `cap_count` always equal the contents of their registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| codec_req_pulse | output | 1 | One-cycle codec write-request event |
| codec_reply_pulse | output | 1 | One-cycle codec read-reply event |
| codec_reg_num | output | DATA_W | Codec register number |
| codec_out_data | output | DATA_W | Data to send to the codec |
| play_en | output | 1 | Playback channel enable |
| play_addr | output | DATA_W | Playback memory address |
| play_count | output | DATA_W | Playback bytes remaining |
| cap_en | output | 1 | Capture channel enable |
| cap_addr | output | DATA_W | Capture memory address |
| cap_count | output | DATA_W | Capture bytes remaining |
| play_upd | input | 1 | Playback address/count update strobe |
| play_upd_addr | input | DATA_W | New playback address |
| play_upd_count | input | DATA_W | New playback count |
| cap_upd | input | 1 | Capture address/count update strobe |
| cap_upd_addr | input | DATA_W | New capture address |
| cap_upd_count | input | DATA_W | New capture count |

## Verification
The assertions assume that the bus write strobe and the update strobes are either 0 or 1 in every clocked cycle after reset. They also assume the address and data are stable around the capturing edge. The bench changes all inputs only on the falling clock edge, so every value is settled before the rising edge that samples it. The update strobes rise only when the bench means to exercise the update port, and the one collision test deliberately lines up a bus write with an update in the same cycle.

// File: rtl/audio_ctrl_regs.sv
module audio_ctrl_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              codec_req_pulse,
  output logic              codec_reply_pulse,
  output logic [DATA_W-1:0] codec_reg_num,
  output logic [DATA_W-1:0] codec_out_data,
  output logic              play_en,
  output logic [DATA_W-1:0] play_addr,
  output logic [DATA_W-1:0] play_count,
  output logic              cap_en,
  output logic [DATA_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_count,
  input  logic              play_upd,
  input  logic [DATA_W-1:0] play_upd_addr,
  input  logic [DATA_W-1:0] play_upd_count,
  input  logic              cap_upd,
  input  logic [DATA_W-1:0] cap_upd_addr,
  input  logic [DATA_W-1:0] cap_upd_count
);
  localparam int IDX_W   = ADDR_W - 2;
  localparam int N_CH    = 2;
  localparam int W_CTRL  = 0;
  localparam int W_NUM   = 1;
  localparam int W_OUT   = 2;
  localparam int W_IN    = 3;
  localparam int CH_BASE = 4;
  localparam int CH_STEP = 4;

  logic [IDX_W-1:0]  widx;
  logic [DATA_W-1:0] ctrl_q, num_q, out_q, in_q;
  logic [DATA_W-1:0] ch_ctrl  [N_CH];
  logic [DATA_W-1:0] ch_addr  [N_CH];
  logic [DATA_W-1:0] ch_count [N_CH];
  logic              upd_v    [N_CH];
  logic [DATA_W-1:0] upd_addr [N_CH];
  logic [DATA_W-1:0] upd_cnt  [N_CH];
  logic              wr_ctrl, kick;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign wr_ctrl = bus_wr && (widx == IDX_W'(W_CTRL));
  assign kick    = wr_ctrl && bus_wdata[0];

  assign upd_v[0] = play_upd;  assign upd_addr[0] = play_upd_addr;  assign upd_cnt[0] = play_upd_count;
  assign upd_v[1] = cap_upd;   assign upd_addr[1] = cap_upd_addr;   assign upd_cnt[1] = cap_upd_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q            <= '0;
      num_q             <= '0;
      out_q             <= '0;
      in_q              <= '0;
      codec_req_pulse   <= 1'b0;
      codec_reply_pulse <= 1'b0;
    end else begin
      codec_req_pulse   <= kick && bus_wdata[1];
      codec_reply_pulse <= kick && !bus_wdata[1];
      if (wr_ctrl) ctrl_q <= {bus_wdata[DATA_W-1:1], 1'b0};
      if (bus_wr && widx == IDX_W'(W_NUM)) num_q <= bus_wdata;
      if (bus_wr && widx == IDX_W'(W_OUT)) out_q <= bus_wdata;
      if (bus_wr && widx == IDX_W'(W_IN))  in_q  <= bus_wdata;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int OFF = CH_BASE + CH_STEP * c;
    logic sel_ctrl, sel_addr, sel_cnt;
    assign sel_ctrl = bus_wr && (widx == IDX_W'(OFF));
    assign sel_addr = bus_wr && (widx == IDX_W'(OFF + 1));
    assign sel_cnt  = bus_wr && (widx == IDX_W'(OFF + 2));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_ctrl[c]  <= '0;
        ch_addr[c]  <= '0;
        ch_count[c] <= '0;
      end else begin
        if (sel_ctrl) ch_ctrl[c] <= bus_wdata;
        if (sel_addr)        ch_addr[c] <= bus_wdata;
        else if (upd_v[c])   ch_addr[c] <= upd_addr[c];
        if (sel_cnt)         ch_count[c] <= bus_wdata;
        else if (upd_v[c])   ch_count[c] <= upd_cnt[c];
      end
    end

    assert_upd_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_v[c] && !sel_addr && !sel_cnt) |=>
        (ch_addr[c] == $past(upd_addr[c]) && ch_count[c] == $past(upd_cnt[c])));
    assert_bus_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_v[c] && sel_addr) |=> (ch_addr[c] == $past(bus_wdata)));
  end

  always_comb begin
    bus_rdata = '0;
    case (widx)
      IDX_W'(W_CTRL): bus_rdata = ctrl_q;
      IDX_W'(W_NUM):  bus_rdata = num_q;
      IDX_W'(W_OUT):  bus_rdata = out_q;
      IDX_W'(W_IN):   bus_rdata = in_q;
      default: begin
        for (int c = 0; c < N_CH; c++) begin
          if (widx == IDX_W'(CH_BASE + CH_STEP * c))     bus_rdata = ch_ctrl[c];
          if (widx == IDX_W'(CH_BASE + CH_STEP * c + 1)) bus_rdata = ch_addr[c];
          if (widx == IDX_W'(CH_BASE + CH_STEP * c + 2)) bus_rdata = ch_count[c];
        end
      end
    endcase
  end

  assign codec_reg_num  = num_q;
  assign codec_out_data = out_q;
  assign play_en    = ch_ctrl[0][0];
  assign play_addr  = ch_addr[0];
  assign play_count = ch_count[0];
  assign cap_en     = ch_ctrl[1][0];
  assign cap_addr   = ch_addr[1];
  assign cap_count  = ch_count[1];

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[0] && bus_wdata[1]) |=> (codec_req_pulse && !codec_reply_pulse));
  assert_reply_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[0] && !bus_wdata[1]) |=> (codec_reply_pulse && !codec_req_pulse));
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && widx == IDX_W'(W_CTRL) && bus_wdata[0]) |=> (!codec_req_pulse && !codec_reply_pulse));
  assert_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl) |=> (ctrl_q[0] == 1'b0 && ctrl_q[DATA_W-1:1] == $past(bus_wdata[DATA_W-1:1])));
endmodule

// File: tb/audio_ctrl_regs_test.sv
module audio_ctrl_regs_test;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          codec_req_pulse, codec_reply_pulse;
  logic [DW-1:0] codec_reg_num, codec_out_data;
  logic          play_en, cap_en;
  logic [DW-1:0] play_addr, play_count, cap_addr, cap_count;
  logic          play_upd = 1'b0, cap_upd = 1'b0;
  logic [DW-1:0] play_upd_addr = '0, play_upd_count = '0;
  logic [DW-1:0] cap_upd_addr = '0, cap_upd_count = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  audio_ctrl_regs #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .codec_req_pulse(codec_req_pulse), .codec_reply_pulse(codec_reply_pulse),
    .codec_reg_num(codec_reg_num), .codec_out_data(codec_out_data),
    .play_en(play_en), .play_addr(play_addr), .play_count(play_count),
    .cap_en(cap_en), .cap_addr(cap_addr), .cap_count(cap_count),
    .play_upd(play_upd), .play_upd_addr(play_upd_addr), .play_upd_count(play_upd_count),
    .cap_upd(cap_upd), .cap_upd_addr(cap_upd_addr), .cap_upd_count(cap_upd_count));

  localparam int NV = 14;
  localparam logic [AW+2*DW-1:0] VEC [NV] = '{
    {8'h00, 32'h0000_0003, 32'h0000_0002},
    {8'h04, 32'h0000_1234, 32'h0000_1234},
    {8'h08, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {8'h0C, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {8'h10, 32'h0000_0001, 32'h0000_0001},
    {8'h14, 32'h8000_0000, 32'h8000_0000},
    {8'h18, 32'h0000_0100, 32'h0000_0100},
    {8'h1C, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h20, 32'h0000_0003, 32'h0000_0003},
    {8'h24, 32'h1234_5678, 32'h1234_5678},
    {8'h28, 32'h0000_0040, 32'h0000_0040},
    {8'h2C, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'hFC, 32'h5555_AAAA, 32'h0000_0000},
    {8'h16, 32'h0000_0055, 32'h0000_0055}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%h expected=%h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      rd(AW'(k * 4), v);
      chk("R7 reset register zero", v, 0);
    end
    chk("R7 reset pulses low", {30'd0, codec_req_pulse, codec_reply_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      a = VEC[i][AW+2*DW-1:2*DW];
      wr(a, VEC[i][2*DW-1:DW]);
      rd(a, v);
      chk("R1 R2 R5 R8 table readback", v, VEC[i][DW-1:0]);
    end
    rd(8'h14, v); chk("R2 word write via unaligned address", v, 32'h55);
    rd(8'h18, v); chk("R8 reserved write left neighbour", v, 32'h100);
    rd(8'h20, v); chk("R8 reserved write left capture ctrl", v, 32'h3);

    chk("R11 codec_reg_num", codec_reg_num, 32'h1234);
    chk("R11 codec_out_data", codec_out_data, 32'hA5A5_5A5A);
    chk("R11 play_addr", play_addr, 32'h55);
    chk("R11 play_count", play_count, 32'h100);
    chk("R11 cap_addr", cap_addr, 32'h1234_5678);
    chk("R11 cap_count", cap_count, 32'h40);
    chk("R6 enables set", {30'd0, play_en, cap_en}, 32'h3);
    wr(8'h10, 32'hFFFF_FFFE);
    chk("R6 play_en cleared", {31'd0, play_en}, 0);
    chk("R6 cap_en kept", {31'd0, cap_en}, 1);

    wr(8'h00, 32'h0000_0003);
    chk("R3 req pulse high", {31'd0, codec_req_pulse}, 1);
    chk("R3 reply stays low", {31'd0, codec_reply_pulse}, 0);
    @(negedge clk); #1;
    chk("R3 req pulse one cycle", {31'd0, codec_req_pulse}, 0);
    wr(8'h00, 32'h0000_0001);
    chk("R4 reply pulse high", {31'd0, codec_reply_pulse}, 1);
    chk("R4 req stays low", {31'd0, codec_req_pulse}, 0);
    @(negedge clk); #1;
    chk("R4 reply pulse one cycle", {31'd0, codec_reply_pulse}, 0);
    wr(8'h00, 32'hF0F0_0002);
    chk("R5 no pulse without request", {30'd0, codec_req_pulse, codec_reply_pulse}, 0);
    rd(8'h00, v); chk("R5 other bits stored", v, 32'hF0F0_0002);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R5 request bit self-clears", v, 32'hFFFF_FFFE);

    @(negedge clk);
    play_upd = 1'b1; play_upd_addr = 32'h0000_2000; play_upd_count = 32'h0000_0080;
    cap_upd = 1'b1;  cap_upd_addr = 32'h0000_3000;  cap_upd_count = 32'h0000_0010;
    @(negedge clk);
    play_upd = 1'b0; cap_upd = 1'b0;
    #1;
    chk("R9 play_addr updated", play_addr, 32'h2000);
    chk("R9 play_count updated", play_count, 32'h80);
    rd(8'h24, v); chk("R9 capture address readback", v, 32'h3000);
    rd(8'h28, v); chk("R9 capture count readback", v, 32'h10);

    @(negedge clk);
    bus_addr = 8'h14; bus_wdata = 32'hCAFE_0000; bus_wr = 1'b1;
    play_upd = 1'b1; play_upd_addr = 32'h0000_4000; play_upd_count = 32'h0000_0007;
    @(negedge clk);
    bus_wr = 1'b0; play_upd = 1'b0;
    rd(8'h14, v); chk("R10 bus write wins address", v, 32'hCAFE_0000);
    rd(8'h18, v); chk("R10 count takes update", v, 32'h7);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      rd(AW'(k * 4), v);
      chk("R7 mid-run reset zero", v, 0);
    end
    chk("R7 outputs zero", play_addr | cap_count | codec_reg_num, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule